// File: doc/BRIEF.md
# Three-Phase Carrier PWM Generator

The block produces three ideal phase PWM signals (U, V, W) from one shared 16-bit carrier counter. The carrier either ramps up and back down (triangle mode), giving pulses centred on the carrier peak, or ramps up and wraps to zero (sawtooth mode), giving pulses that start at the cycle boundary. The counter advances on a tick picked from the clock divided by 1, 2, 8 or 32, or from an external slow tick strobe. Dead time insertion and pin driving belong to the stages that follow this block.

Each phase has a rising-half width register and a falling-half width register. The falling-half register is used only when dual-width mode is on, so a triangle pulse can extend by different amounts on each side of the peak. The period, widths, mode bits and per-phase force controls are all sampled together at the carrier boundary. A write made in the middle of a cycle therefore takes effect from the next cycle and never cuts a pulse short. A carrier interrupt strobe fires once every 1 to 15 carrier cycles.

Top module: `pwm3_carrier_gen`

## Requirements
- R1: While reset is asserted, all three phase outputs and the interrupt output are 0.
- R2: In sawtooth mode (tri_mode=0), with period setting m and width n, a carrier cycle lasts m+1 ticks. A phase is 1 for the first n ticks of the cycle and 0 for the rest.
- R3: In triangle mode (tri_mode=1), a carrier cycle lasts 2*(m+1) ticks. A phase is 1 for one unbroken run of 2*n ticks centred on the carrier peak.
- R4: In triangle mode with dual_wid=1, a phase stays 1 for n_rise ticks before the peak and n_fall ticks after it. The rise widths come from wid_rise and the fall widths from wid_fall. With dual_wid=0, wid_rise sets both halves, and sawtooth mode uses wid_rise only.
- R5: src_sel selects the tick: 0 = every clock, 1 = every 2nd clock, 2 = every 8th clock, 3 = every 32nd clock, 4 = each clock in which slow_tick is 1. Codes 5 to 7 behave as code 0. The counter holds between ticks.
- R6: A width of 0 keeps the phase at 0 for the whole cycle. A width of at least m+1 keeps the phase at 1 for the whole cycle.
- R7: Period, widths, modes and force controls are sampled only at the carrier boundary. A change made mid-cycle leaves the current cycle unchanged and applies from the next one.
- R8: carrier_irq is a one-clock pulse in the first clock of a carrier cycle, once every irq_ratio cycles (1 to 15). A ratio of 0 behaves as 1.
- R9: If force_en[i] is 1 at a boundary, phase i drives force_lvl[i] for the entire next carrier cycle instead of its PWM value. Bit 0 is U, bit 1 is V and bit 2 is W, and the same bit order applies to phase_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Tick source code |
| slow_tick | input | 1 | External slow tick strobe |
| tri_mode | input | 1 | 1 = triangle carrier, 0 = sawtooth |
| dual_wid | input | 1 | 1 = separate rise/fall widths |
| period_m | input | 16 | Carrier period setting m |
| wid_rise | input | 48 | Per-phase widths, 16 bits each, U in bits 15:0 |
| wid_fall | input | 48 | Per-phase falling-half widths, same packing |
| irq_ratio | input | 4 | Carrier cycles per interrupt |
| force_en | input | 3 | Per-phase force enable |
| force_lvl | input | 3 | Per-phase forced level |
| phase_out | output | 3 | U/V/W PWM outputs |
| carrier_irq | output | 1 | Carrier interrupt strobe |

## Verification
The bound checks watch the carrier counter on every cycle. They confirm that it holds between ticks, stays within the latched period, never counts down in sawtooth mode and turns at the peak in triangle mode. They also confirm that the latched period changes only at a boundary and that every interrupt follows a boundary. Pulse widths, period lengths for each tick source, the centring of triangle pulses, the interrupt spacing and the one-cycle force override are measured only by the bench's scenarios. Each scenario counts clocks between interrupts and phase-high clocks inside one carrier cycle.

// File: rtl/pwm3_carrier_gen.sv
module pwm3_carrier_gen #(
  parameter int CW  = 16,
  parameter int NPH = 3,
  parameter int RW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         src_sel,
  input  logic               slow_tick,
  input  logic               tri_mode,
  input  logic               dual_wid,
  input  logic [CW-1:0]      period_m,
  input  logic [NPH*CW-1:0]  wid_rise,
  input  logic [NPH*CW-1:0]  wid_fall,
  input  logic [RW-1:0]      irq_ratio,
  input  logic [NPH-1:0]     force_en,
  input  logic [NPH-1:0]     force_lvl,
  output logic [NPH-1:0]     phase_out,
  output logic               carrier_irq
);
  localparam int PW = 5;

  logic [PW-1:0]     presc;
  logic              tick;
  logic [CW-1:0]     cnt, m_lat;
  logic              dir_dn, tri_lat, dual_lat, primed;
  logic [NPH*CW-1:0] wr_lat, wf_lat;
  logic [NPH-1:0]    fen_lat, flv_lat;
  logic [RW-1:0]     skip;
  logic              at_top, bnd;
  logic [RW-1:0]     ratio_eff;
  logic [CW:0]       thr;

  always_ff @(posedge clk) begin
    if (!rst_n) presc <= '0;
    else        presc <= presc + 1'b1;
  end

  always_comb begin
    case (src_sel)
      3'd1:    tick = presc[0];
      3'd2:    tick = &presc[2:0];
      3'd3:    tick = &presc;
      3'd4:    tick = slow_tick;
      default: tick = 1'b1;
    endcase
  end

  assign at_top    = (cnt == m_lat);
  assign bnd       = primed && tick && (tri_lat ? (dir_dn && cnt == '0) : at_top);
  assign ratio_eff = (irq_ratio == '0) ? RW'(1) : irq_ratio;
  assign thr       = {1'b0, m_lat} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; m_lat <= '0; dir_dn <= 1'b0; tri_lat <= 1'b0; dual_lat <= 1'b0;
      primed <= 1'b0; wr_lat <= '0; wf_lat <= '0; fen_lat <= '0; flv_lat <= '0;
      skip <= '0; carrier_irq <= 1'b0;
    end else begin
      carrier_irq <= 1'b0;
      if (!primed || bnd) begin
        cnt      <= '0;
        dir_dn   <= 1'b0;
        primed   <= 1'b1;
        m_lat    <= period_m;
        tri_lat  <= tri_mode;
        dual_lat <= dual_wid;
        wr_lat   <= wid_rise;
        wf_lat   <= wid_fall;
        fen_lat  <= force_en;
        flv_lat  <= force_lvl;
        if (!primed) skip <= ratio_eff;
        else if (skip <= RW'(1)) begin
          carrier_irq <= 1'b1;
          skip        <= ratio_eff;
        end else skip <= skip - 1'b1;
      end else if (tick) begin
        if (!tri_lat)      cnt <= cnt + 1'b1;
        else if (!dir_dn) begin
          if (at_top) dir_dn <= 1'b1;
          else        cnt    <= cnt + 1'b1;
        end else           cnt <= cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic [CW-1:0] wr, wf;
    logic          tri_on, saw_on;
    assign wr     = wr_lat[g*CW +: CW];
    assign wf     = dual_lat ? wf_lat[g*CW +: CW] : wr;
    assign tri_on = dir_dn ? (({1'b0, cnt} + {1'b0, wf}) >= thr)
                           : (({1'b0, cnt} + {1'b0, wr}) >= thr);
    assign saw_on = cnt < wr;
    assign phase_out[g] = fen_lat[g] ? flv_lat[g] : (tri_lat ? tri_on : saw_on);
  end
endmodule

// File: rtl/pwm3_carrier_gen_chk.sv
module pwm3_carrier_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bnd,
  input logic          primed,
  input logic          tri_lat,
  input logic          dir_dn,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] m_lat,
  input logic          carrier_irq
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !tick) |=> $stable(cnt));  // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (cnt <= m_lat));  // R2
  AST_SAW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !tri_lat) |-> !dir_dn);  // R2
  AST_TRI_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && tri_lat && tick && !dir_dn && cnt == m_lat) |=> dir_dn);  // R3
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !bnd) |=> $stable(m_lat));  // R7
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_irq |-> $past(bnd));  // R8
endmodule

bind pwm3_carrier_gen pwm3_carrier_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bnd(bnd), .primed(primed),
  .tri_lat(tri_lat), .dir_dn(dir_dn), .cnt(cnt), .m_lat(m_lat),
  .carrier_irq(carrier_irq)
);

// File: tb/sim_pwm3_carrier_gen.sv
`timescale 1ns/1ps
module sim_pwm3_carrier_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = 3'd0;
  logic        slow_tick = 1'b0;
  logic        tri_mode = 1'b0;
  logic        dual_wid = 1'b0;
  logic [15:0] period_m = 16'd9;
  logic [47:0] wid_rise = '0;
  logic [47:0] wid_fall = '0;
  logic [3:0]  irq_ratio = 4'd1;
  logic [2:0]  force_en = '0;
  logic [2:0]  force_lvl = '0;
  logic [2:0]  phase_out;
  logic        carrier_irq;

  int n_chk = 0, n_bad = 0;
  int mlen;
  int mhi[3];
  int sdiv = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    sdiv = (sdiv == 4) ? 0 : sdiv + 1;
    slow_tick = (sdiv == 0);
  end

  pwm3_carrier_gen u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .slow_tick(slow_tick),
    .tri_mode(tri_mode), .dual_wid(dual_wid), .period_m(period_m),
    .wid_rise(wid_rise), .wid_fall(wid_fall), .irq_ratio(irq_ratio),
    .force_en(force_en), .force_lvl(force_lvl), .phase_out(phase_out),
    .carrier_irq(carrier_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_w(input int u, input int v, input int w);
    wid_rise = {w[15:0], v[15:0], u[15:0]};
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!carrier_irq);
  endtask

  // starts on an irq negedge, ends on the next one
  task automatic measure();
    mlen = 0;
    for (int i = 0; i < 3; i++) mhi[i] = 0;
    do begin
      mlen++;
      for (int i = 0; i < 3; i++) mhi[i] += int'(phase_out[i]);
      @(negedge clk);
    end while (!carrier_irq);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", int'(phase_out), 0);
    chk("R1 irq in reset", int'(carrier_irq), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_saw();
    tri_mode = 0; period_m = 9; set_w(3, 7, 12);
    wait_irq(); wait_irq(); measure();
    chk("R2 saw period", mlen, 10);
    chk("R2 saw width U", mhi[0], 3);
    chk("R2 saw width V", mhi[1], 7);
    chk("R6 wide W full", mhi[2], 10);
  endtask

  task automatic t_tri();
    tri_mode = 1; period_m = 7; set_w(2, 8, 0);
    wait_irq(); wait_irq(); measure();
    chk("R3 tri period", mlen, 16);
    chk("R3 tri width U", mhi[0], 4);
    chk("R6 tri full V", mhi[1], 16);
    chk("R6 zero W", mhi[2], 0);
  endtask

  task automatic t_tri_center();
    int first, last, idx;
    tri_mode = 1; period_m = 7; set_w(3, 0, 0);
    wait_irq(); wait_irq();
    first = -1; last = -1; idx = 0;
    do begin
      if (phase_out[0]) begin
        if (first < 0) first = idx;
        last = idx;
      end
      idx++;
      @(negedge clk);
    end while (!carrier_irq);
    chk("R3 tri pulse start", first, 5);
    chk("R3 tri pulse end", last, 10);
  endtask

  task automatic t_dual();
    tri_mode = 1; dual_wid = 1; period_m = 9; set_w(2, 3, 5);
    wid_fall = {16'd5, 16'd1, 16'd4};
    wait_irq(); wait_irq(); measure();
    chk("R4 dual period", mlen, 20);
    chk("R4 dual U", mhi[0], 6);
    chk("R4 dual V", mhi[1], 4);
    chk("R4 dual W", mhi[2], 10);
    tri_mode = 0;
    wait_irq(); wait_irq(); measure();
    chk("R4 saw ignores fall V", mhi[1], 3);
    dual_wid = 0;
  endtask

  task automatic t_src();
    int plen[5] = '{10, 20, 80, 320, 50};
    int phi[5]  = '{2, 4, 16, 64, 10};
    tri_mode = 0; period_m = 9; set_w(2, 0, 0);
    for (int s = 0; s < 5; s++) begin
      src_sel = 3'(s);
      wait_irq(); wait_irq(); measure();
      chk($sformatf("R5 src %0d period", s), mlen, plen[s]);
      chk($sformatf("R5 src %0d width", s), mhi[0], phi[s]);
    end
    src_sel = 3'd6;
    wait_irq(); wait_irq(); measure();
    chk("R5 src 6 as 0", mlen, 10);
    src_sel = 3'd0;
  endtask

  task automatic t_latch();
    tri_mode = 0; period_m = 9; set_w(3, 0, 0);
    wait_irq(); wait_irq();
    period_m = 4; set_w(6, 0, 0);
    measure();
    chk("R7 old period kept", mlen, 10);
    chk("R7 old width kept", mhi[0], 3);
    measure();
    chk("R7 new period", mlen, 5);
    chk("R7 new width", mhi[0], 5);
    period_m = 9;
  endtask

  task automatic t_irq();
    int gap;
    tri_mode = 0; period_m = 9; irq_ratio = 3;
    wait_irq(); wait_irq();
    @(negedge clk);
    chk("R8 irq one clock", int'(carrier_irq), 0);
    gap = 1;
    while (!carrier_irq) begin @(negedge clk); gap++; end
    chk("R8 ratio 3 gap", gap, 30);
    irq_ratio = 0;
    wait_irq(); wait_irq(); measure();
    chk("R8 ratio 0 as 1", mlen, 10);
    irq_ratio = 1;
  endtask

  task automatic t_force();
    tri_mode = 0; period_m = 9; set_w(3, 7, 0);
    wait_irq(); wait_irq();
    force_en = 3'b011; force_lvl = 3'b001;
    measure();
    chk("R9 before force U", mhi[0], 3);
    measure();
    chk("R9 forced high U", mhi[0], 10);
    chk("R9 forced low V", mhi[1], 0);
    force_en = 3'b000;
    measure();
    chk("R9 one cycle only U", mhi[0], 10);
    measure();
    chk("R9 released U", mhi[0], 3);
    chk("R9 released V", mhi[1], 7);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_saw();
    t_tri();
    t_tri_center();
    t_dual();
    t_src();
    t_latch();
    t_irq();
    t_force();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule